// File: doc/BRIEF.md
# SCSI Controller Command Front-End

This block is the byte-wide register window and command decoder that sits in front of a SCSI bus controller. A host reaches sixteen byte registers through a 6-bit address, of which bits 5:2 pick the register. Through this window it sets a 16-bit transfer count and moves bytes through a small data FIFO. It also writes commands, and it reads back the status, interrupt and sequence-step codes that each command leaves behind.

Many commands finish at once inside the block and load fixed codes. Selection with attention and transfer-information commands need the bus, so they go out to an external target port as one-cycle request pulses. When the target port pulses back that it is done, the block loads the completion codes and raises its interrupt line. Reading the interrupt register is the acknowledge. It drops the interrupt line and the DMA interrupt-pending flag, and it clears every status bit except terminal count.

Top module: `scsi_cmd_frontend`

## Requirements
- R1: After reset, registers 0–8, 11, 12, 13 and 15 read 0x00, register 14 reads 0x04, and `irq`, `dma_irq_pend`, `dma_mode`, `sel_req` and `xfer_req` are low.
- R2: Registers 0 and 1 hold the low and high bytes of the 16-bit transfer count and read back as written. A write to register 11 keeps only the bits of mask 0x15.
- R3: A write to register 2 pushes a byte into the FIFO unless it holds FIFO_DEPTH bytes, in which case the byte is dropped. A read of register 2 pops the oldest byte only while the FIFO is non-empty; when it is empty the read returns the last byte popped. Register 7 reads the byte count, and the FIFO keeps its order across refills.
- R4: A command write to register 3 stores the value, which reads back from register 3, and copies its bit 7 to `dma_mode`. Bits 6:0 are the opcode.
- R5: Opcode 0x01 sets interrupt = 0x08 and step = 0 and raises no interrupt. Opcode 0x00 and any opcode not listed here leave status, interrupt, step and `irq` unchanged.
- R6: Opcode 0x02 returns every register, the FIFO and the outputs to their R1 values. Register 14 then reads 0x04 again.
- R7: Opcode 0x03 sets interrupt = 0x80. It raises `irq` and `dma_irq_pend` only when bit 6 of register 8 is clear.
- R8: Opcodes 0x42 and 0x43 read the target ID from bits 2:0 of the value last written to register 4. An ID of NUM_TARGETS or more completes at once with status 0x80, interrupt 0x20, step 0 and `irq` raised, and no `sel_req` is issued.
- R9: For a present target, `sel_req` is high for exactly the one cycle after the command is accepted, with `sel_target` equal to the ID. A `tgt_done` pulse then loads status 0x91 (interrupt bit 0x80, terminal count 0x10, data-in phase 1), interrupt 0x18 and step 4, and raises `irq`.
- R10: Opcode 0x10 pulses `xfer_req` for one cycle. A `tgt_done` pulse then loads status 0x93 (status phase 3), interrupt 0x10 and step 0, and raises `irq`.
- R11: Opcodes 0x11 and 0x12 each hand back two zero bytes and raise `irq`. With bit 7 clear, the FIFO is reloaded to hold exactly two 0x00 bytes. With bit 7 set, the block loads status 0x93, interrupt 0x18 and step 4. Opcode 0x12 then overrides interrupt with 0x20 and step with 0.
- R12: A read of register 5 returns the interrupt code, leaves that code unchanged, clears every status bit except bit 4, and drops `irq` and `dma_irq_pend`.
- R13: While a target request is outstanding, every command except 0x02 is ignored. A `tgt_done` pulse with nothing outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address; bits 5:2 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt line |
| dma_irq_pend | output | 1 | DMA interrupt-pending flag |
| dma_mode | output | 1 | DMA flag from bit 7 of the last accepted command |
| sel_req | output | 1 | One-cycle request to select `sel_target` with attention |
| sel_target | output | 3 | Target ID of the current selection |
| xfer_req | output | 1 | One-cycle request to run an information transfer |
| tgt_done | input | 1 | One-cycle completion pulse from the target port |

## Verification
Every register write and every command that completes at once takes effect at the clock edge that samples the strobe, so its results are due one cycle after the stimulus. Read data is registered and due one edge after `bus_rd`. The monitor waits for the falling edge that follows the sampling edge, pops its expected byte from the scoreboard queue and compares there. Request pulses are seen at the first falling edge after the command edge. Completion codes follow the edge that samples `tgt_done`, and the bench waits several whole cycles before it reads them back, so no check depends on the order of processes at a clock edge.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;

  localparam int unsigned TGT_W     = 3;
  localparam int unsigned MISC_BASE = 12;
  localparam int unsigned MISC_N    = 4;
  localparam int unsigned R14_SLOT  = 2;

  // register indices (address bits 5:2)
  localparam logic [3:0] RI_CNT_LO = 4'd0;
  localparam logic [3:0] RI_CNT_HI = 4'd1;
  localparam logic [3:0] RI_FIFO   = 4'd2;
  localparam logic [3:0] RI_CMD    = 4'd3;
  localparam logic [3:0] RI_STAT   = 4'd4;
  localparam logic [3:0] RI_INTR   = 4'd5;
  localparam logic [3:0] RI_SEQ    = 4'd6;
  localparam logic [3:0] RI_FLAGS  = 4'd7;
  localparam logic [3:0] RI_CFG    = 4'd8;
  localparam logic [3:0] RI_MASKED = 4'd11;

  // command opcodes
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_RESET    = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_CMPL     = 7'h11;
  localparam logic [6:0] OP_MSG_ACC  = 7'h12;
  localparam logic [6:0] OP_SEL_ATN  = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;

  // status bits and bus phases
  localparam logic [7:0] ST_IRQ = 8'h80;
  localparam logic [7:0] ST_TC  = 8'h10;
  typedef enum logic [2:0] {
    PH_DOUT = 3'd0, PH_DIN = 3'd1, PH_CMD = 3'd2, PH_STAT = 3'd3,
    PH_MIN  = 3'd6, PH_MOUT = 3'd7
  } phase_e;

  // interrupt codes and sequence steps
  localparam logic [7:0] IN_FC  = 8'h08;
  localparam logic [7:0] IN_BS  = 8'h10;
  localparam logic [7:0] IN_DC  = 8'h20;
  localparam logic [7:0] IN_RST = 8'h80;
  localparam logic [7:0] SQ_IDLE = 8'h00;
  localparam logic [7:0] SQ_DONE = 8'h04;

  localparam logic [7:0] MASK_R11  = 8'h15;
  localparam logic [7:0] RESET_R14 = 8'h04;
  localparam int unsigned CFG_NOIRQ_BIT = 6;

  typedef enum logic [1:0] { WT_NONE, WT_SEL, WT_XFER } wait_e;

  typedef struct packed {
    logic       set_st;
    logic [7:0] st;
    logic       set_in;
    logic [7:0] intr;
    logic       set_sq;
    logic [7:0] sq;
    logic       raise;
  } code_upd_t;

  function automatic logic [3:0] reg_index(input logic [5:0] addr);
    return addr[5:2];
  endfunction

  function automatic logic [7:0] status_word(input logic tc, input phase_e ph);
    return ST_IRQ | (tc ? ST_TC : 8'h00) | {5'd0, ph};
  endfunction

  function automatic logic [7:0] status_after_ack(input logic [7:0] s);
    return s & ST_TC;
  endfunction

  function automatic logic [7:0] mask_r11(input logic [7:0] v);
    return v & MASK_R11;
  endfunction

endpackage

// File: rtl/scsi_fe_fifo.sv
module scsi_fe_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  input  logic          ld_zero,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt_q != FULL);
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (do_push && !do_pop) cnt_nxt = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ld_zero) begin
      mem[0] <= '0;
      mem[1] <= '0;
    end else if (do_push) begin
      mem[wptr_q] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (ld_zero) begin
      rptr_q <= '0;
      wptr_q <= PW'(2);
      cnt_q  <= CW'(2);
    end else begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == '0) begin
        rptr_q <= '0;
        wptr_q <= '0;
      end else begin
        if (do_push) wptr_q <= ptr_inc(wptr_q);
        if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      end
    end
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/scsi_fe_cmd.sv
module scsi_fe_cmd
  import scsi_fe_pkg::*;
#(
  parameter int unsigned NUM_TGT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_val,
  input  logic [TGT_W-1:0] target_id,
  input  logic             cfg_noirq,
  input  logic             tgt_done,
  output logic             busy,
  output logic             cmd_fire,
  output logic [6:0]       cmd_op,
  output logic             soft_reset,
  output logic             fifo_ld_zero,
  output logic             tgt_absent,
  output logic             sel_req,
  output logic             xfer_req,
  output logic [TGT_W-1:0] sel_target,
  output code_upd_t        upd
);

  wait_e            wait_q;
  logic             start_sel, start_xfer, cmd_dma, finish;
  logic             sel_req_q, xfer_req_q;
  logic [TGT_W-1:0] sel_target_q;

  assign cmd_op     = cmd_val[6:0];
  assign cmd_dma    = cmd_val[7];
  assign busy       = (wait_q != WT_NONE);
  assign cmd_fire   = cmd_wr && (!busy || cmd_op == OP_RESET);
  assign tgt_absent = (32'(target_id) >= NUM_TGT);
  assign finish     = busy && tgt_done && !cmd_fire;

  always_comb begin
    upd          = '0;
    soft_reset   = 1'b0;
    fifo_ld_zero = 1'b0;
    start_sel    = 1'b0;
    start_xfer   = 1'b0;
    if (cmd_fire) begin
      case (cmd_op)
        OP_FLUSH: begin
          upd.set_in = 1'b1; upd.intr = IN_FC;
          upd.set_sq = 1'b1; upd.sq   = SQ_IDLE;
        end
        OP_RESET: soft_reset = 1'b1;
        OP_BUS_RST: begin
          upd.set_in = 1'b1; upd.intr = IN_RST;
          upd.raise  = !cfg_noirq;
        end
        OP_XFER: start_xfer = 1'b1;
        OP_CMPL, OP_MSG_ACC: begin
          upd.raise = 1'b1;
          if (cmd_dma) begin
            upd.set_st = 1'b1; upd.st   = status_word(1'b1, PH_STAT);
            upd.set_in = 1'b1; upd.intr = IN_BS | IN_FC;
            upd.set_sq = 1'b1; upd.sq   = SQ_DONE;
          end else begin
            fifo_ld_zero = 1'b1;
          end
          if (cmd_op == OP_MSG_ACC) begin
            upd.set_in = 1'b1; upd.intr = IN_DC;
            upd.set_sq = 1'b1; upd.sq   = SQ_IDLE;
          end
        end
        OP_SEL_ATN, OP_SEL_STOP: begin
          if (tgt_absent) begin
            upd.set_st = 1'b1; upd.st   = ST_IRQ;
            upd.set_in = 1'b1; upd.intr = IN_DC;
            upd.set_sq = 1'b1; upd.sq   = SQ_IDLE;
            upd.raise  = 1'b1;
          end else begin
            start_sel = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (finish) begin
      upd.raise  = 1'b1;
      upd.set_st = 1'b1;
      upd.set_in = 1'b1;
      upd.set_sq = 1'b1;
      if (wait_q == WT_SEL) begin
        upd.st   = status_word(1'b1, PH_DIN);
        upd.intr = IN_BS | IN_FC;
        upd.sq   = SQ_DONE;
      end else begin
        upd.st   = status_word(1'b1, PH_STAT);
        upd.intr = IN_BS;
        upd.sq   = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q       <= WT_NONE;
      sel_req_q    <= 1'b0;
      xfer_req_q   <= 1'b0;
      sel_target_q <= '0;
    end else begin
      sel_req_q  <= start_sel;
      xfer_req_q <= start_xfer;
      if (soft_reset) begin
        wait_q       <= WT_NONE;
        sel_target_q <= '0;
      end else if (start_sel) begin
        wait_q       <= WT_SEL;
        sel_target_q <= target_id;
      end else if (start_xfer) begin
        wait_q <= WT_XFER;
      end else if (finish) begin
        wait_q <= WT_NONE;
      end
    end
  end

  assign sel_req    = sel_req_q;
  assign xfer_req   = xfer_req_q;
  assign sel_target = sel_target_q;

endmodule

// File: rtl/scsi_cmd_frontend.sv
module scsi_cmd_frontend
  import scsi_fe_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned NUM_TARGETS = 4,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       dma_irq_pend,
  output logic       dma_mode,
  output logic       sel_req,
  output logic [2:0] sel_target,
  output logic       xfer_req,
  input  logic       tgt_done
);

  logic [3:0]       idx;
  logic [15:0]      cnt_q;
  logic [7:0]       cmd_q, status_q, intr_q, seq_q, cfg_q, r11_q, last_pop_q, rdata_q;
  logic [TGT_W-1:0] tgt_q;
  logic             dma_q, irq_q, pend_q;
  logic [7:0]       misc_rd [MISC_N];
  logic [7:0]       rd_mux;

  // named internal events
  logic             cmd_wr, cmd_fire, soft_reset, fifo_ld_zero, busy, tgt_absent;
  logic             rd_intr, evt_raise, fifo_push, fifo_pop;
  logic [6:0]       cmd_op;
  code_upd_t        upd;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_count;

  assign idx       = reg_index(bus_addr);
  assign cmd_wr    = bus_wr && (idx == RI_CMD);
  assign fifo_push = bus_wr && (idx == RI_FIFO);
  assign fifo_pop  = bus_rd && (idx == RI_FIFO);
  assign rd_intr   = bus_rd && (idx == RI_INTR);
  assign evt_raise = upd.raise;

  scsi_fe_cmd #(.NUM_TGT(NUM_TARGETS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(bus_wdata),
    .target_id(tgt_q), .cfg_noirq(cfg_q[CFG_NOIRQ_BIT]), .tgt_done(tgt_done),
    .busy(busy), .cmd_fire(cmd_fire), .cmd_op(cmd_op), .soft_reset(soft_reset),
    .fifo_ld_zero(fifo_ld_zero), .tgt_absent(tgt_absent), .sel_req(sel_req),
    .xfer_req(xfer_req), .sel_target(sel_target), .upd(upd)
  );

  scsi_fe_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_reset), .push(fifo_push), .pop(fifo_pop),
    .wdata(bus_wdata), .ld_zero(fifo_ld_zero), .head(fifo_head), .count(fifo_count)
  );

  // plain storage registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; cfg_q <= '0; r11_q <= '0; tgt_q <= '0;
    end else if (soft_reset) begin
      cnt_q <= '0; cfg_q <= '0; r11_q <= '0; tgt_q <= '0;
    end else if (bus_wr) begin
      case (idx)
        RI_CNT_LO: cnt_q[7:0]  <= bus_wdata;
        RI_CNT_HI: cnt_q[15:8] <= bus_wdata;
        RI_STAT:   tgt_q       <= bus_wdata[TGT_W-1:0];
        RI_CFG:    cfg_q       <= bus_wdata;
        RI_MASKED: r11_q       <= mask_r11(bus_wdata);
        default: ;
      endcase
    end
  end

  // scratch registers 12..15
  for (genvar g = 0; g < MISC_N; g++) begin : g_misc
    localparam logic [7:0] RST_V = (g == R14_SLOT) ? RESET_R14 : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_V;
      else if (soft_reset) q <= RST_V;
      else if (bus_wr && idx == 4'(MISC_BASE + g)) q <= bus_wdata;
    end
    assign misc_rd[g] = q;
  end

  // command register and DMA flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; dma_q <= 1'b0;
    end else if (soft_reset) begin
      cmd_q <= '0; dma_q <= 1'b0;
    end else if (cmd_fire) begin
      cmd_q <= bus_wdata; dma_q <= bus_wdata[7];
    end
  end

  // status / interrupt / step codes and the interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0; intr_q <= '0; seq_q <= '0; irq_q <= 1'b0; pend_q <= 1'b0;
    end else if (soft_reset) begin
      status_q <= '0; intr_q <= '0; seq_q <= '0; irq_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (upd.set_st)   status_q <= upd.st;
      else if (rd_intr) status_q <= status_after_ack(status_q);
      if (upd.set_in) intr_q <= upd.intr;
      if (upd.set_sq) seq_q  <= upd.sq;
      if (upd.raise) begin
        irq_q <= 1'b1; pend_q <= 1'b1;
      end else if (rd_intr) begin
        irq_q <= 1'b0; pend_q <= 1'b0;
      end
    end
  end

  // read path
  always_comb begin
    rd_mux = 8'h00;
    case (idx)
      RI_CNT_LO: rd_mux = cnt_q[7:0];
      RI_CNT_HI: rd_mux = cnt_q[15:8];
      RI_FIFO:   rd_mux = (fifo_count != '0) ? fifo_head : last_pop_q;
      RI_CMD:    rd_mux = cmd_q;
      RI_STAT:   rd_mux = status_q;
      RI_INTR:   rd_mux = intr_q;
      RI_SEQ:    rd_mux = seq_q;
      RI_FLAGS:  rd_mux = 8'(fifo_count);
      RI_CFG:    rd_mux = cfg_q;
      RI_MASKED: rd_mux = r11_q;
      default:   if (idx >= 4'(MISC_BASE)) rd_mux = misc_rd[idx[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0; last_pop_q <= '0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      if (soft_reset) last_pop_q <= '0;
      else if (fifo_pop && fifo_count != '0) last_pop_q <= fifo_head;
    end
  end

  assign bus_rdata    = rdata_q;
  assign irq          = irq_q;
  assign dma_irq_pend = pend_q;
  assign dma_mode     = dma_q;

endmodule

// File: rtl/scsi_fe_checker.sv
module scsi_fe_checker
  import scsi_fe_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_req,
  input logic          xfer_req,
  input logic          irq,
  input logic          dma_irq_pend,
  input logic          dma_mode,
  input logic          rd_intr,
  input logic          evt_raise,
  input logic [7:0]    status_q,
  input logic [CW-1:0] fifo_count,
  input logic          cmd_fire,
  input logic [6:0]    cmd_op,
  input logic [7:0]    cmd_val,
  input logic          tgt_absent,
  input logic          busy
);

  a_r9_sel_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> !sel_req);

  a_r10_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_intr && !evt_raise) |=> (!irq && !dma_irq_pend && ((status_q & ~ST_TC) == 8'h00)));

  a_r8_absent_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && (cmd_op == OP_SEL_ATN || cmd_op == OP_SEL_STOP) && tgt_absent) |=> !sel_req);

  a_r4_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op != OP_RESET) |=> (dma_mode == $past(cmd_val[7])));

  a_r13_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_fire) |-> (cmd_op == OP_RESET));

endmodule

bind scsi_cmd_frontend scsi_fe_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .xfer_req(xfer_req), .irq(irq),
  .dma_irq_pend(dma_irq_pend), .dma_mode(dma_mode), .rd_intr(rd_intr),
  .evt_raise(evt_raise), .status_q(status_q), .fifo_count(fifo_count),
  .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_val(bus_wdata),
  .tgt_absent(tgt_absent), .busy(busy)
);

// File: tb/test_scsi_cmd_frontend.sv
`timescale 1ns/1ps
module test_scsi_cmd_frontend;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, dma_irq_pend, dma_mode, sel_req, xfer_req;
  logic [2:0] sel_target;
  logic       tgt_done = 1'b0;

  int n_tests = 0, n_fail = 0;
  int sel_seen = 0, xfer_seen = 0;
  logic [2:0] sel_tgt_seen = '0;
  bit auto_ack = 1'b1;
  bit done_flag = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  scsi_cmd_frontend i_scsi_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_irq_pend(dma_irq_pend),
    .dma_mode(dma_mode), .sel_req(sel_req), .sel_target(sel_target), .xfer_req(xfer_req),
    .tgt_done(tgt_done)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    bus_addr = {idx, 2'b01}; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = {idx, 2'b10}; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: read data due one edge after the strobe
  always @(posedge clk) begin
    if (rst_n && bus_rd) begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(bus_rdata == e, t, 16'(bus_rdata), 16'(e));
      end
    end
  end

  // target port model
  initial begin
    forever begin
      @(negedge clk);
      if (sel_req || xfer_req) begin
        if (sel_req) begin sel_seen++; sel_tgt_seen = sel_target; end
        else xfer_seen++;
        if (auto_ack) begin
          settle(2);
          tgt_done = 1'b1;
          @(negedge clk);
          tgt_done = 1'b0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    check(!irq && !dma_irq_pend && !dma_mode && !sel_req && !xfer_req, "R1 outputs after reset",
          {11'd0, irq, dma_irq_pend, dma_mode, sel_req, xfer_req}, 16'h0);
    rd(4'd4, 8'h00, "R1 status reset");
    rd(4'd6, 8'h00, "R1 step reset");
    rd(4'd5, 8'h00, "R1 interrupt reset");
    rd(4'd7, 8'h00, "R1 fifo count reset");
    rd(4'd14, 8'h04, "R1 reg14 reset");
    rd(4'd13, 8'h00, "R1 reg13 reset");

    // R2 transfer count and masked register
    wr(4'd0, 8'h34); wr(4'd1, 8'h12);
    rd(4'd0, 8'h34, "R2 count low");
    rd(4'd1, 8'h12, "R2 count high");
    wr(4'd11, 8'hFF);
    rd(4'd11, 8'h15, "R2 reg11 mask");

    // R3 FIFO
    wr(4'd2, 8'hA1); wr(4'd2, 8'hB2); wr(4'd2, 8'hC3);
    rd(4'd7, 8'h03, "R3 count after three pushes");
    rd(4'd2, 8'hA1, "R3 pop first");
    rd(4'd2, 8'hB2, "R3 pop second");
    rd(4'd2, 8'hC3, "R3 pop third");
    rd(4'd7, 8'h00, "R3 count empty");
    rd(4'd2, 8'hC3, "R3 empty read holds last");
    rd(4'd7, 8'h00, "R3 empty read no underflow");
    wr(4'd2, 8'h5A);
    rd(4'd2, 8'h5A, "R3 refill after drain");
    for (int i = 0; i < 17; i++) wr(4'd2, 8'(8'h40 + i));
    rd(4'd7, 8'h10, "R3 count saturates at depth");
    for (int i = 0; i < 16; i++) rd(4'd2, 8'(8'h40 + i), "R3 full fifo order");
    rd(4'd7, 8'h00, "R3 drained");

    // R4 command register and DMA flag
    wr(4'd3, 8'h80);
    check(dma_mode == 1'b1, "R4 dma flag set", 16'(dma_mode), 16'h1);
    rd(4'd3, 8'h80, "R4 command readback");
    wr(4'd3, 8'h00);
    check(dma_mode == 1'b0, "R4 dma flag clear", 16'(dma_mode), 16'h0);
    rd(4'd5, 8'h00, "R5 nop leaves interrupt");

    // R9 selection of a present target
    wr(4'd4, 8'h02);
    wr(4'd3, 8'h42);
    settle(6);
    check(sel_seen == 1, "R9 one selection request", 16'(sel_seen), 16'd1);
    check(sel_tgt_seen == 3'd2, "R9 selected target", 16'(sel_tgt_seen), 16'd2);
    check(irq && dma_irq_pend, "R9 irq after completion", {14'd0, irq, dma_irq_pend}, 16'h3);
    rd(4'd4, 8'h91, "R9 status");
    rd(4'd6, 8'h04, "R9 step");
    rd(4'd5, 8'h18, "R9 interrupt");
    check(!irq && !dma_irq_pend, "R12 irq dropped by interrupt read", {14'd0, irq, dma_irq_pend}, 16'h0);
    rd(4'd4, 8'h10, "R12 status keeps terminal count");
    rd(4'd5, 8'h18, "R12 interrupt code kept");

    // R5 flush and unknown opcode
    wr(4'd3, 8'h01);
    check(!irq, "R5 flush raises no irq", 16'(irq), 16'h0);
    rd(4'd5, 8'h08, "R5 flush interrupt");
    rd(4'd6, 8'h00, "R5 flush step");
    wr(4'd3, 8'h55);
    check(!irq, "R5 unknown opcode no irq", 16'(irq), 16'h0);
    rd(4'd5, 8'h08, "R5 unknown opcode interrupt unchanged");
    rd(4'd4, 8'h10, "R5 unknown opcode status unchanged");

    // R8 absent target
    wr(4'd4, 8'h05);
    wr(4'd3, 8'hC3);
    check(irq == 1'b1, "R8 irq on absent target", 16'(irq), 16'h1);
    settle(4);
    check(sel_seen == 1, "R8 no request for absent target", 16'(sel_seen), 16'd1);
    rd(4'd4, 8'h80, "R8 status");
    rd(4'd6, 8'h00, "R8 step");
    rd(4'd5, 8'h20, "R8 interrupt");
    rd(4'd4, 8'h00, "R12 status cleared after absent");

    // R10 transfer information
    wr(4'd3, 8'h90);
    settle(6);
    check(xfer_seen == 1, "R10 transfer request", 16'(xfer_seen), 16'd1);
    check(irq == 1'b1, "R10 irq after completion", 16'(irq), 16'h1);
    rd(4'd4, 8'h93, "R10 status");
    rd(4'd6, 8'h00, "R10 step");
    rd(4'd5, 8'h10, "R10 interrupt");

    // R7 bus reset, masked then unmasked
    wr(4'd8, 8'h40);
    wr(4'd3, 8'h03);
    check(!irq && !dma_irq_pend, "R7 masked bus reset no irq", {14'd0, irq, dma_irq_pend}, 16'h0);
    rd(4'd5, 8'h80, "R7 masked bus reset code");
    wr(4'd8, 8'h00);
    wr(4'd3, 8'h03);
    check(irq && dma_irq_pend, "R7 bus reset irq", {14'd0, irq, dma_irq_pend}, 16'h3);
    rd(4'd5, 8'h80, "R7 bus reset code");

    // R11 completion and message accepted
    wr(4'd3, 8'h11);
    check(irq == 1'b1, "R11 irq after non-dma complete", 16'(irq), 16'h1);
    rd(4'd7, 8'h02, "R11 two bytes in fifo");
    rd(4'd2, 8'h00, "R11 first zero byte");
    rd(4'd2, 8'h00, "R11 second zero byte");
    rd(4'd5, 8'h80, "R11 non-dma complete leaves interrupt");
    wr(4'd3, 8'h91);
    rd(4'd4, 8'h93, "R11 dma complete status");
    rd(4'd6, 8'h04, "R11 dma complete step");
    rd(4'd5, 8'h18, "R11 dma complete interrupt");
    wr(4'd3, 8'h92);
    check(irq == 1'b1, "R11 irq after message accepted", 16'(irq), 16'h1);
    rd(4'd4, 8'h93, "R11 message accepted status");
    rd(4'd6, 8'h00, "R11 message accepted step");
    rd(4'd5, 8'h20, "R11 message accepted interrupt");

    // R13 busy blocking and stray completion
    auto_ack = 1'b0;
    wr(4'd4, 8'h01);
    wr(4'd3, 8'h42);
    settle(2);
    check(sel_seen == 2 && sel_tgt_seen == 3'd1, "R13 request outstanding", 16'(sel_seen), 16'd2);
    wr(4'd3, 8'h01);
    rd(4'd5, 8'h20, "R13 flush ignored while busy");
    @(negedge clk); tgt_done = 1'b1;
    @(negedge clk); tgt_done = 1'b0;
    check(irq == 1'b1, "R13 completion after manual done", 16'(irq), 16'h1);
    rd(4'd5, 8'h18, "R13 selection completed");
    @(negedge clk); tgt_done = 1'b1;
    @(negedge clk); tgt_done = 1'b0;
    settle(1);
    check(irq == 1'b0, "R13 stray done ignored irq", 16'(irq), 16'h0);
    rd(4'd4, 8'h10, "R13 stray done ignored status");
    auto_ack = 1'b1;

    // R6 chip reset
    wr(4'd14, 8'h77);
    rd(4'd14, 8'h77, "R6 reg14 written");
    wr(4'd0, 8'h99);
    wr(4'd3, 8'h80);
    wr(4'd3, 8'h82);
    check(dma_mode == 1'b0, "R6 dma flag cleared", 16'(dma_mode), 16'h0);
    rd(4'd14, 8'h04, "R6 reg14 restored");
    rd(4'd0, 8'h00, "R6 count cleared");
    rd(4'd3, 8'h00, "R6 command cleared");
    rd(4'd11, 8'h00, "R6 reg11 cleared");
    rd(4'd5, 8'h00, "R6 interrupt cleared");

    settle(3);
    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule